// File: doc/BRIEF.md
# Function Unit to Register Dependency Matrix

This block tracks which architectural registers each in-flight operation still has to read and which one it will write. It is organised as a matrix with one row per function-unit slot and one column per register. Every ALU owns a fixed group of rows. An operation issued to an ALU takes the lowest free row of that group. Because one ALU can hold several waiting operations, each row keeps its own copy of both source operands, much as a reservation station does.

At issue, each source is resolved in one of three ways. If no row is going to write the register, the value offered by the register file is taken. If the register's writer completes in the same cycle, the write-back value is forwarded. Otherwise the row waits: it marks the operand as needing a read and captures it later, when the write-back for that register arrives. The destination is marked as needing a write until the row's own write-back, which also frees the row. For each register, the OR of each column is output as pending-write and pending-read vectors. Issue is refused (stalled) when the target ALU has no free row, or when the destination already has a pending writer.

Top module: `fu_reg_matrix`

## Requirements
- R1: After reset all rows are free (`row_busy` = 0), `pend_write` and `pend_read` are all zero, and `issue_stall` is low.
- R2: An accepted issue to ALU a takes the lowest-numbered free row among rows a*ROWS_PER_ALU to a*ROWS_PER_ALU+ROWS_PER_ALU-1. `issue_row` shows that row in the issue cycle, and the row's `row_busy` bit is set from the next cycle.
- R3: From the cycle after an accepted issue, `pend_write[dst]` is high and remains high until the write-back of that row.
- R4: A source whose register has a pending writer, with no write-back to that register in the issue cycle, sets `pend_read` for that register. The row's `row_ready` stays low until the operand is captured.
- R5: A source whose register has no pending writer is captured from `issue_rf0` (first source, `row_opa`) or `issue_rf1` (second source, `row_opb`) in the issue cycle.
- R6: A source whose pending writer is written back in the issue cycle takes `wb_data` in place of the register-file value and does not set `pend_read`.
- R7: A waiting operand captures `wb_data` when a write-back to its register occurs. Its `pend_read` contribution then clears, and the row becomes ready once no operand is still waiting.
- R8: During a write-back, `wb_dst` shows the destination register of row `wb_row` in the same cycle. From the next cycle that row is free and its need-write bit is cleared.
- R9: An issue to an ALU whose rows are all busy raises `issue_stall`, and no row is allocated.
- R10: An issue whose destination register already has a pending writer raises `issue_stall` and is not accepted, so that at most one row writes any register.
- R11: Rows owned by the same ALU hold independent operand copies; issuing to one row never alters the captured values of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_alu | input | ALU_W | Target ALU of the issue |
| issue_src0 | input | REG_W | First source register |
| issue_src1 | input | REG_W | Second source register |
| issue_dst | input | REG_W | Destination register |
| issue_rf0 | input | DATA_W | Register-file value of first source |
| issue_rf1 | input | DATA_W | Register-file value of second source |
| issue_stall | output | 1 | Issue refused this cycle |
| issue_row | output | ROW_W | Row allocated by an accepted issue |
| wb_valid | input | 1 | Write-back of a row's result |
| wb_row | input | ROW_W | Row completing |
| wb_data | input | DATA_W | Result value |
| wb_dst | output | REG_W | Destination register of `wb_row` |
| pend_write | output | NUM_REGS | Per-register OR of need-write bits |
| pend_read | output | NUM_REGS | Per-register OR of need-read bits |
| row_busy | output | ROWS | Row occupied |
| row_ready | output | ROWS | Row occupied with both operands captured |
| row_opa | output | ROWS*DATA_W | First captured operand per row, row i at bits i*DATA_W |
| row_opb | output | ROWS*DATA_W | Second captured operand per row |

## Verification
Operand resolution is exercised with three source patterns: a free register, a register with a pending writer that completes later, and one whose writer completes in the issue cycle. Each pattern leaves a different value in the row and a different `pend_read` state, so register-file capture, deferred capture and forwarding can be distinguished from one another. Allocation is driven by filling one ALU's rows while the other ALU stays empty, then freeing a row. This separates the lowest-free choice, the per-ALU grouping and the full-group stall. A second writer to a busy destination checks that the write-after-write stall is distinct from the occupancy stall.

// File: rtl/fu_mtx_pkg.sv
package fu_mtx_pkg;
   localparam int NSRC = 2;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fu_mtx_alloc.sv
module fu_mtx_alloc import fu_mtx_pkg::*; #(
   parameter int NUM_ALU      = 2,
   parameter int ROWS_PER_ALU = 2,
   localparam int ROWS        = NUM_ALU * ROWS_PER_ALU,
   localparam int ALU_W       = idx_w(NUM_ALU),
   localparam int ROW_W       = idx_w(ROWS)
) (
   input  logic [ALU_W-1:0] alu_sel,
   input  logic [ROWS-1:0]  busy,
   output logic             has_free,
   output logic [ROW_W-1:0] pick
);
   always_comb begin
      has_free = 1'b0;
      pick     = '0;
      if (int'(alu_sel) < NUM_ALU) begin
         for (int j = ROWS_PER_ALU - 1; j >= 0; j--) begin
            if (!busy[int'(alu_sel) * ROWS_PER_ALU + j]) begin
               has_free = 1'b1;
               pick     = ROW_W'(int'(alu_sel) * ROWS_PER_ALU + j);
            end
         end
      end
   end
endmodule

// File: rtl/fu_mtx_row.sv
module fu_mtx_row import fu_mtx_pkg::*; #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   localparam int REG_W   = idx_w(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             alloc,
   input  logic [REG_W-1:0]                 iss_dst,
   input  logic [NSRC-1:0][REG_W-1:0]       iss_src,
   input  logic [NSRC-1:0]                  iss_wait,
   input  logic [NSRC-1:0][DATA_W-1:0]      iss_val,
   input  logic                             wb_valid,
   input  logic [REG_W-1:0]                 wb_reg,
   input  logic [DATA_W-1:0]                wb_data,
   input  logic                             retire,
   output logic                             busy,
   output logic [REG_W-1:0]                 dst,
   output logic [NUM_REGS-1:0]              need_write,
   output logic [NUM_REGS-1:0]              need_read,
   output logic                             ready,
   output logic [NSRC-1:0][DATA_W-1:0]      ops
);
   logic                         busy_q;
   logic [REG_W-1:0]             dst_q;
   logic [NSRC-1:0][REG_W-1:0]   src_q;
   logic [NSRC-1:0]              wait_q;
   logic [NSRC-1:0][DATA_W-1:0]  val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dst_q  <= '0;
         src_q  <= '0;
         wait_q <= '0;
         val_q  <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1;
         dst_q  <= iss_dst;
         src_q  <= iss_src;
         wait_q <= iss_wait;
         val_q  <= iss_val;
      end else if (busy_q) begin
         if (retire) begin
            busy_q <= 1'b0;
            wait_q <= '0;
         end else begin
            for (int k = 0; k < NSRC; k++) begin
               if (wait_q[k] && wb_valid && wb_reg == src_q[k]) begin
                  val_q[k]  <= wb_data;
                  wait_q[k] <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      need_write = '0;
      need_read  = '0;
      if (busy_q) begin
         need_write[dst_q] = 1'b1;
         for (int k = 0; k < NSRC; k++)
            if (wait_q[k]) need_read[src_q[k]] = 1'b1;
      end
   end

   assign busy  = busy_q;
   assign dst   = dst_q;
   assign ready = busy_q && (wait_q == '0);
   assign ops   = val_q;

   AST_RETIRE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> ready); // R8

   AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      retire && !alloc |=> !busy && need_write == '0); // R8

   for (genvar k = 0; k < NSRC; k++) begin : g_slot_chk
      AST_OPERAND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         busy_q && !retire && wait_q[k] && wb_valid && wb_reg == src_q[k]
         |=> !wait_q[k] && ops[k] == $past(wb_data)); // R7
   end
endmodule

// File: rtl/fu_reg_matrix.sv
module fu_reg_matrix import fu_mtx_pkg::*; #(
   parameter int NUM_ALU      = 2,
   parameter int ROWS_PER_ALU = 2,
   parameter int NUM_REGS     = 8,
   parameter int DATA_W       = 16,
   localparam int ROWS        = NUM_ALU * ROWS_PER_ALU,
   localparam int ALU_W       = idx_w(NUM_ALU),
   localparam int ROW_W       = idx_w(ROWS),
   localparam int REG_W       = idx_w(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     issue_valid,
   input  logic [ALU_W-1:0]         issue_alu,
   input  logic [REG_W-1:0]         issue_src0,
   input  logic [REG_W-1:0]         issue_src1,
   input  logic [REG_W-1:0]         issue_dst,
   input  logic [DATA_W-1:0]        issue_rf0,
   input  logic [DATA_W-1:0]        issue_rf1,
   output logic                     issue_stall,
   output logic [ROW_W-1:0]         issue_row,
   input  logic                     wb_valid,
   input  logic [ROW_W-1:0]         wb_row,
   input  logic [DATA_W-1:0]        wb_data,
   output logic [REG_W-1:0]         wb_dst,
   output logic [NUM_REGS-1:0]      pend_write,
   output logic [NUM_REGS-1:0]      pend_read,
   output logic [ROWS-1:0]          row_busy,
   output logic [ROWS-1:0]          row_ready,
   output logic [ROWS*DATA_W-1:0]   row_opa,
   output logic [ROWS*DATA_W-1:0]   row_opb
);
   if (NUM_ALU < 1 || ROWS_PER_ALU < 1 || NUM_REGS < 2 || DATA_W < 1) begin : g_param_err
      $error("fu_reg_matrix: illegal parameter set");
   end

   logic [NUM_REGS-1:0]          nw [ROWS];
   logic [NUM_REGS-1:0]          nr [ROWS];
   logic [REG_W-1:0]             row_dst [ROWS];
   logic [NSRC-1:0][DATA_W-1:0]  row_ops [ROWS];
   logic [NSRC-1:0][REG_W-1:0]   iss_src;
   logic [NSRC-1:0][DATA_W-1:0]  iss_rf;
   logic [NSRC-1:0][DATA_W-1:0]  iss_val;
   logic [NSRC-1:0]              iss_wait;
   logic                         has_free;
   logic [ROW_W-1:0]             pick;
   logic                         accept;

   fu_mtx_alloc #(.NUM_ALU(NUM_ALU), .ROWS_PER_ALU(ROWS_PER_ALU)) u_alloc (
      .alu_sel  (issue_alu),
      .busy     (row_busy),
      .has_free (has_free),
      .pick     (pick)
   );

   assign issue_stall = issue_valid && (!has_free || pend_write[issue_dst]);
   assign accept      = issue_valid && !issue_stall;
   assign issue_row   = pick;

   always_comb begin
      wb_dst = '0;
      if (int'(wb_row) < ROWS) wb_dst = row_dst[wb_row];
   end

   // operand resolution: register file, same-cycle forward, or wait
   assign iss_src[0] = issue_src0;
   assign iss_src[1] = issue_src1;
   assign iss_rf[0]  = issue_rf0;
   assign iss_rf[1]  = issue_rf1;

   always_comb begin
      for (int k = 0; k < NSRC; k++) begin
         iss_wait[k] = 1'b0;
         iss_val[k]  = iss_rf[k];
         if (pend_write[iss_src[k]]) begin
            if (wb_valid && wb_dst == iss_src[k]) begin
               iss_val[k] = wb_data;
            end else begin
               iss_wait[k] = 1'b1;
               iss_val[k]  = '0;
            end
         end
      end
   end

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      fu_mtx_row #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_row (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (accept && pick == ROW_W'(i)),
         .iss_dst    (issue_dst),
         .iss_src    (iss_src),
         .iss_wait   (iss_wait),
         .iss_val    (iss_val),
         .wb_valid   (wb_valid),
         .wb_reg     (wb_dst),
         .wb_data    (wb_data),
         .retire     (wb_valid && wb_row == ROW_W'(i)),
         .busy       (row_busy[i]),
         .dst        (row_dst[i]),
         .need_write (nw[i]),
         .need_read  (nr[i]),
         .ready      (row_ready[i]),
         .ops        (row_ops[i])
      );
      assign row_opa[i*DATA_W +: DATA_W] = row_ops[i][0];
      assign row_opb[i*DATA_W +: DATA_W] = row_ops[i][1];
   end

   always_comb begin
      pend_write = '0;
      pend_read  = '0;
      for (int i = 0; i < ROWS; i++) begin
         pend_write = pend_write | nw[i];
         pend_read  = pend_read  | nr[i];
      end
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_col
      logic [ROWS-1:0] col_w;
      for (genvar i = 0; i < ROWS; i++) begin : g_bit
         assign col_w[i] = nw[i][r];
      end
      AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(col_w) <= 1); // R10
   end

   AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      issue_stall && !wb_valid |=> row_busy == $past(row_busy)); // R9

   AST_WB_ROW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> row_busy[wb_row]); // R8

   AST_ISSUE_MARKS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> pend_write[$past(issue_dst)] && row_busy[$past(issue_row)]); // R3
endmodule

// File: tb/fu_reg_matrix_tb.sv
module fu_reg_matrix_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue_valid;
   logic [0:0]  issue_alu;
   logic [2:0]  issue_src0, issue_src1, issue_dst;
   logic [15:0] issue_rf0, issue_rf1;
   logic        issue_stall;
   logic [1:0]  issue_row;
   logic        wb_valid;
   logic [1:0]  wb_row;
   logic [15:0] wb_data;
   logic [2:0]  wb_dst;
   logic [7:0]  pend_write, pend_read;
   logic [3:0]  row_busy, row_ready;
   logic [63:0] row_opa, row_opb;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   fu_reg_matrix u_dut (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_alu(issue_alu),
      .issue_src0(issue_src0), .issue_src1(issue_src1), .issue_dst(issue_dst),
      .issue_rf0(issue_rf0), .issue_rf1(issue_rf1),
      .issue_stall(issue_stall), .issue_row(issue_row),
      .wb_valid(wb_valid), .wb_row(wb_row), .wb_data(wb_data), .wb_dst(wb_dst),
      .pend_write(pend_write), .pend_read(pend_read),
      .row_busy(row_busy), .row_ready(row_ready),
      .row_opa(row_opa), .row_opb(row_opb)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] opa(input int r); return row_opa[r*16 +: 16]; endfunction
   function automatic logic [15:0] opb(input int r); return row_opb[r*16 +: 16]; endfunction

   // all tasks start and end at a falling edge
   task automatic set_issue(input int alu, s0, s1, d, input logic [15:0] rf0, rf1);
      issue_valid = 1'b1;
      issue_alu   = alu[0:0];
      issue_src0  = s0[2:0];
      issue_src1  = s1[2:0];
      issue_dst   = d[2:0];
      issue_rf0   = rf0;
      issue_rf1   = rf1;
   endtask

   task automatic do_issue(input int alu, s0, s1, d, input logic [15:0] rf0, rf1,
                           output logic st, output logic [1:0] rw);
      set_issue(alu, s0, s1, d, rf0, rf1);
      #2;
      st = issue_stall;
      rw = issue_row;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic do_wb(input int row, input logic [15:0] data, output logic [2:0] dst);
      wb_valid = 1'b1;
      wb_row   = row[1:0];
      wb_data  = data;
      #2;
      dst = wb_dst;
      @(negedge clk);
      wb_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 row_busy", row_busy, 0);
      chk("R1 pend_write", pend_write, 0);
      chk("R1 pend_read", pend_read, 0);
      chk("R1 issue_stall", issue_stall, 0);
   endtask

   task automatic t_basic;
      logic st; logic [1:0] rw; logic [2:0] d;
      do_issue(0, 1, 2, 3, 16'h0011, 16'h0022, st, rw);
      chk("R2 no stall", st, 0);
      chk("R2 row", rw, 0);
      chk("R2 busy", row_busy, 4'b0001);
      chk("R3 pend_write", pend_write, 8'h08);
      chk("R5 ready", row_ready[0], 1);
      chk("R5 opa", opa(0), 16'h0011);
      chk("R5 opb", opb(0), 16'h0022);
      do_wb(0, 16'h0033, d);
      chk("R8 wb_dst", d, 3);
      chk("R8 freed", row_busy, 0);
      chk("R8 pend_write clear", pend_write, 0);
   endtask

   task automatic t_wait;
      logic st; logic [1:0] rw; logic [2:0] d;
      do_issue(0, 1, 2, 4, 16'h0001, 16'h0002, st, rw);
      do_issue(1, 4, 5, 6, 16'h00AA, 16'h00BB, st, rw);
      chk("R2 alu1 row", rw, 2);
      chk("R4 pend_read", pend_read, 8'h10);
      chk("R4 not ready", row_ready[2], 0);
      chk("R5 opb from rf", opb(2), 16'h00BB);
      do_wb(0, 16'h0044, d);
      chk("R7 ready", row_ready[2], 1);
      chk("R7 captured", opa(2), 16'h0044);
      chk("R7 pend_read clear", pend_read, 0);
      chk("R3 remaining writer", pend_write, 8'h40);
      do_wb(2, 16'h0000, d);
   endtask

   task automatic t_forward;
      logic st; logic [1:0] rw; logic [2:0] d;
      do_issue(0, 0, 0, 7, 16'h0000, 16'h0000, st, rw);
      wb_valid = 1'b1; wb_row = 2'd0; wb_data = 16'h0077;
      set_issue(1, 7, 1, 2, 16'hDEAD, 16'h0055);
      #2;
      st = issue_stall;
      @(negedge clk);
      wb_valid = 1'b0; issue_valid = 1'b0;
      chk("R6 no stall", st, 0);
      chk("R6 forwarded", opa(2), 16'h0077);
      chk("R6 ready", row_ready[2], 1);
      chk("R6 no pend_read", pend_read, 0);
      chk("R6 opb rf", opb(2), 16'h0055);
      do_wb(2, 16'h0000, d);
   endtask

   task automatic t_full;
      logic st; logic [1:0] rw; logic [2:0] d;
      do_issue(0, 0, 0, 1, 16'h0100, 16'h0200, st, rw);
      do_issue(0, 0, 0, 2, 16'h0300, 16'h0400, st, rw);
      chk("R2 second row", rw, 1);
      chk("R11 row0 opa", opa(0), 16'h0100);
      chk("R11 row0 opb", opb(0), 16'h0200);
      chk("R11 row1 opa", opa(1), 16'h0300);
      do_issue(0, 0, 0, 3, 16'h0500, 16'h0600, st, rw);
      chk("R9 stall", st, 1);
      chk("R9 busy unchanged", row_busy, 4'b0011);
      chk("R9 no new writer", pend_write, 8'h06);
      do_issue(1, 0, 0, 3, 16'h0500, 16'h0600, st, rw);
      chk("R2 other alu", st, 0);
      chk("R2 other alu row", rw, 2);
      do_wb(0, 16'h0001, d);
      do_issue(0, 0, 0, 4, 16'h0700, 16'h0800, st, rw);
      chk("R2 reuse lowest", rw, 0);
      chk("R11 row1 kept", opa(1), 16'h0300);
      do_wb(0, 16'h0, d);
      do_wb(1, 16'h0, d);
      do_wb(2, 16'h0, d);
      chk("R8 all free", row_busy, 0);
   endtask

   task automatic t_waw;
      logic st; logic [1:0] rw; logic [2:0] d;
      do_issue(0, 0, 0, 5, 16'h0, 16'h0, st, rw);
      do_issue(1, 0, 0, 5, 16'h0, 16'h0, st, rw);
      chk("R10 waw stall", st, 1);
      chk("R10 busy", row_busy, 4'b0001);
      do_wb(0, 16'h0, d);
      do_issue(1, 0, 0, 5, 16'h0, 16'h0, st, rw);
      chk("R10 accepted after wb", st, 0);
      chk("R10 writer", pend_write, 8'h20);
      do_wb(2, 16'h0, d);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; issue_valid = 1'b0; issue_alu = '0;
      issue_src0 = '0; issue_src1 = '0; issue_dst = '0;
      issue_rf0 = '0; issue_rf1 = '0;
      wb_valid = 1'b0; wb_row = '0; wb_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wait();
      t_forward();
      t_full();
      t_waw();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule